// File: doc/BRIEF.md
# Burst-Aligned Approximation Span Selector

This block sits in front of a variable-length encoder for 128-byte memory blocks made of 64 symbols of 16 bits. It receives the code length of every symbol and a threshold, in bits, that software chose for the region being written. A binary adder tree adds the lengths to get the encoded size of the block. From that size the block decides how many 32-byte bursts the block will occupy. It then picks one of three storage modes: raw (unencoded), exact (lossless) or trimmed (lossy).

Trimmed mode is used when the encoded size spills only a few bits past a whole number of bursts. The bits past the last full burst are called the overflow. Trimmed mode is allowed when the overflow is no larger than the threshold. The block then reuses the partial sums of the adder tree to find the narrowest run of adjacent symbols whose combined length covers the overflow. The encoder can drop that run and save one burst. Two tree levels carry extra half-offset nodes so that the chosen run is less coarse. The result is registered and appears a fixed two cycles after the input, whatever tree level was chosen.

Top module: `approx_span_selector`

## Requirements
- R1: When the encoded size exceeds 1024 bits, out_mode is 2 (raw), out_bursts is 3, and out_start and out_count are 0.
- R2: When the encoded size is below 256 bits, out_mode is 0 (exact) and out_bursts is 0.
- R3: When the encoded size is a nonzero multiple of 256 bits (at most 1024), out_mode is 0 and out_bursts is size/256 − 1. In every exact or raw result, out_start and out_count are 0.
- R4: When the overflow (size mod 256) is nonzero and not above in_thresh, and a run of at most 16 symbols covers it, out_mode is 1 (trimmed) and out_bursts is floor(size/256) − 1.
- R5: When the overflow is above in_thresh, out_mode is 0 and out_bursts is floor(size/256), that is, the rounded-up burst count minus one.
- R6: In trimmed mode the selected level is the lowest tree level L (0..4) that has a node whose summed length is at least the overflow. out_count is 2^L and out_start is the first symbol of that node.
- R7: Within the selected level, the node with the lowest start symbol among the covering nodes is chosen.
- R8: Levels 2 and 3 also offer offset nodes of the same span: span 4 starting at 8k+2 (k = 0..7), and span 8 starting at 16k+4 (k = 0..3). They compete by start symbol with the aligned nodes.
- R9: When no run of 16 or fewer symbols covers the overflow, the result falls back to R5 behaviour (out_mode 0, out_bursts floor(size/256)).
- R10: out_valid is a one-cycle pulse two clock cycles after an in_valid cycle. The result fields hold their values while out_valid is low.
- R11: While rst_n is low, out_valid and all result fields are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Code lengths and threshold are valid this cycle |
| in_lens | input | 320 | 64 code lengths of 5 bits; symbol i in bits [5i+4:5i] |
| in_thresh | input | 8 | Largest overflow, in bits, that may be trimmed |
| out_valid | output | 1 | Result strobe |
| out_mode | output | 2 | 0 exact, 1 trimmed, 2 raw |
| out_bursts | output | 2 | Burst count minus one |
| out_start | output | 6 | First symbol to trim |
| out_count | output | 5 | Number of symbols to trim (power of two up to 16) |

## Verification
The bench builds the block with its default parameters: 64 symbols, 5-bit lengths, 256-bit bursts, a 1024-bit block, a 16-symbol cap, and offset nodes on levels 2 and 3. With these values, random length profiles can reach every burst count, the raw case and the cap fallback. Encoded sizes span 0 to 1984 bits, and a random threshold from 0 to 255 covers the whole overflow range. Directed profiles place a covering run first at an offset node and then at a low single symbol, so the offset nodes and the lowest-index priority are exercised explicitly.

// File: rtl/aps_pkg.sv
package aps_pkg;
    typedef enum logic [1:0] {
        MODE_EXACT   = 2'd0,
        MODE_TRIMMED = 2'd1,
        MODE_RAW     = 2'd2
    } store_mode_e;
endpackage

// File: rtl/aps_adder_tree.sv
// Combinational code-length adder tree; also forms half-offset nodes
// on the fine levels from pairs of the level below.
module aps_adder_tree #(
    parameter int NUM_SYM = 64,
    parameter int LEN_W   = 5,
    parameter int SUM_W   = 11,
    parameter int LVLS    = 6,
    parameter int FINE_LO = 2,
    parameter int FINE_HI = 3
) (
    input  logic [NUM_SYM*LEN_W-1:0]                   lens_i,
    output logic [LVLS:0][NUM_SYM-1:0][SUM_W-1:0]      node_o,
    output logic [LVLS:0][NUM_SYM/2-1:0][SUM_W-1:0]    fine_o
);
    for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
        for (genvar i = 0; i < NUM_SYM; i++) begin : g_node
            if (l == 0) begin : g_leaf
                assign node_o[l][i] = SUM_W'(lens_i[i*LEN_W +: LEN_W]);
            end else if (i < (NUM_SYM >> l)) begin : g_add
                assign node_o[l][i] = node_o[l-1][2*i] + node_o[l-1][2*i+1];
            end else begin : g_pad
                assign node_o[l][i] = '0;
            end
        end
        for (genvar k = 0; k < NUM_SYM/2; k++) begin : g_fine
            if (l >= 1 && l >= FINE_LO && l <= FINE_HI && k < (NUM_SYM >> (l+1))) begin : g_off
                assign fine_o[l][k] = node_o[l-1][4*k+1] + node_o[l-1][4*k+2];
            end else begin : g_none
                assign fine_o[l][k] = '0;
            end
        end
    end
endmodule

// File: rtl/aps_budget.sv
// Burst budget, overflow and mode pre-decision from the encoded size.
module aps_budget #(
    parameter int SUM_W      = 11,
    parameter int THR_W      = 8,
    parameter int BURST_BITS = 256,
    parameter int BLOCK_BITS = 1024,
    parameter int BCNT_W     = 2
) (
    input  logic [SUM_W-1:0]  size_i,
    input  logic [THR_W-1:0]  thr_i,
    output logic              raw_o,
    output logic              try_trim_o,
    output logic [SUM_W-1:0]  over_o,
    output logic [BCNT_W-1:0] bcnt_tight_o,
    output logic [BCNT_W-1:0] bcnt_safe_o
);
    localparam int SH = $clog2(BURST_BITS);

    logic [SUM_W-1:0] whole;
    logic [SUM_W-1:0] rem;

    always_comb begin
        whole        = size_i >> SH;
        rem          = size_i & SUM_W'(BURST_BITS - 1);
        raw_o        = 1'b0;
        try_trim_o   = 1'b0;
        over_o       = '0;
        bcnt_tight_o = '0;
        bcnt_safe_o  = '0;
        if (size_i > SUM_W'(BLOCK_BITS)) begin
            raw_o        = 1'b1;
            bcnt_tight_o = '1;
            bcnt_safe_o  = '1;
        end else if (whole == '0) begin
            bcnt_tight_o = '0;
            bcnt_safe_o  = '0;
        end else if (rem == '0) begin
            bcnt_tight_o = BCNT_W'(whole - SUM_W'(1));
            bcnt_safe_o  = BCNT_W'(whole - SUM_W'(1));
        end else begin
            over_o       = rem;
            try_trim_o   = (rem <= SUM_W'(thr_i));
            bcnt_tight_o = BCNT_W'(whole - SUM_W'(1));
            bcnt_safe_o  = BCNT_W'(whole);
        end
    end
endmodule

// File: rtl/aps_level_pick.sv
// Per-level compare and priority encode: lowest start symbol whose
// node sum covers the requested bit count.
module aps_level_pick #(
    parameter int NUM_SYM  = 64,
    parameter int SUM_W    = 11,
    parameter int IDX_W    = 6,
    parameter int LVL      = 0,
    parameter bit HAS_FINE = 1'b0
) (
    input  logic [NUM_SYM-1:0][SUM_W-1:0]   node_i,
    input  logic [NUM_SYM/2-1:0][SUM_W-1:0] fine_i,
    input  logic [SUM_W-1:0]                need_i,
    output logic                            hit_o,
    output logic [IDX_W-1:0]                start_o
);
    localparam int NODES  = NUM_SYM >> LVL;
    localparam int FNODES = HAS_FINE ? (NUM_SYM >> (LVL + 1)) : 0;
    localparam int SPAN   = 1 << LVL;

    logic             al_hit;
    logic             of_hit;
    logic [IDX_W-1:0] al_start;
    logic [IDX_W-1:0] of_start;

    always_comb begin
        al_hit   = 1'b0;
        al_start = '0;
        for (int i = NODES - 1; i >= 0; i--) begin
            if (node_i[i] >= need_i) begin
                al_hit   = 1'b1;
                al_start = IDX_W'(i * SPAN);
            end
        end
        of_hit   = 1'b0;
        of_start = '0;
        for (int k = FNODES - 1; k >= 0; k--) begin
            if (fine_i[k] >= need_i) begin
                of_hit   = 1'b1;
                of_start = IDX_W'(k * 2 * SPAN + SPAN / 2);
            end
        end
        hit_o   = al_hit | of_hit;
        start_o = al_start;
        if (of_hit && (!al_hit || of_start < al_start)) begin
            start_o = of_start;
        end
    end
endmodule

// File: rtl/approx_span_selector.sv
module approx_span_selector
    import aps_pkg::*;
#(
    parameter int NUM_SYM    = 64,
    parameter int LEN_W      = 5,
    parameter int BURST_BITS = 256,
    parameter int BLOCK_BITS = 1024,
    parameter int MAX_APPROX = 16,
    parameter int FINE_LO    = 2,
    parameter int FINE_HI    = 3,
    localparam int SUM_W     = $clog2(NUM_SYM * ((1 << LEN_W) - 1) + 1),
    localparam int LVLS      = $clog2(NUM_SYM),
    localparam int IDX_W     = LVLS,
    localparam int THR_W     = $clog2(BURST_BITS),
    localparam int BCNT_W    = $clog2(BLOCK_BITS / BURST_BITS),
    localparam int MAX_LVL   = $clog2(MAX_APPROX),
    localparam int CNT_W     = MAX_LVL + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [NUM_SYM*LEN_W-1:0] in_lens,
    input  logic [THR_W-1:0]         in_thresh,
    output logic                     out_valid,
    output logic [1:0]               out_mode,
    output logic [BCNT_W-1:0]        out_bursts,
    output logic [IDX_W-1:0]         out_start,
    output logic [CNT_W-1:0]         out_count
);
    typedef struct packed {
        logic                                   vld;
        logic [THR_W-1:0]                       thr;
        logic [LVLS:0][NUM_SYM-1:0][SUM_W-1:0]  node;
        logic [LVLS:0][NUM_SYM/2-1:0][SUM_W-1:0] fine;
    } sum_stage_t;

    typedef struct packed {
        logic              vld;
        store_mode_e       mode;
        logic [BCNT_W-1:0] bursts;
        logic [IDX_W-1:0]  start;
        logic [CNT_W-1:0]  count;
    } pick_stage_t;

    sum_stage_t  sum_d,  sum_q;
    pick_stage_t pick_d, pick_q;

    logic [LVLS:0][NUM_SYM-1:0][SUM_W-1:0]   tree_node;
    logic [LVLS:0][NUM_SYM/2-1:0][SUM_W-1:0] tree_fine;

    logic              is_raw;
    logic              try_trim;
    logic [SUM_W-1:0]  overflow;
    logic [BCNT_W-1:0] bcnt_tight;
    logic [BCNT_W-1:0] bcnt_safe;

    logic [MAX_LVL:0]            lvl_hit;
    logic [MAX_LVL:0][IDX_W-1:0] lvl_start;
    logic                        sel_hit;
    int                          sel_lvl;

    aps_adder_tree #(
        .NUM_SYM (NUM_SYM),
        .LEN_W   (LEN_W),
        .SUM_W   (SUM_W),
        .LVLS    (LVLS),
        .FINE_LO (FINE_LO),
        .FINE_HI (FINE_HI)
    ) u_tree (
        .lens_i (in_lens),
        .node_o (tree_node),
        .fine_o (tree_fine)
    );

    // Stage 1: capture all partial sums.
    always_comb begin
        sum_d     = sum_q;
        sum_d.vld = in_valid;
        if (in_valid) begin
            sum_d.thr  = in_thresh;
            sum_d.node = tree_node;
            sum_d.fine = tree_fine;
        end
    end

    aps_budget #(
        .SUM_W      (SUM_W),
        .THR_W      (THR_W),
        .BURST_BITS (BURST_BITS),
        .BLOCK_BITS (BLOCK_BITS),
        .BCNT_W     (BCNT_W)
    ) u_budget (
        .size_i       (sum_q.node[LVLS][0]),
        .thr_i        (sum_q.thr),
        .raw_o        (is_raw),
        .try_trim_o   (try_trim),
        .over_o       (overflow),
        .bcnt_tight_o (bcnt_tight),
        .bcnt_safe_o  (bcnt_safe)
    );

    for (genvar l = 0; l <= MAX_LVL; l++) begin : g_pick
        aps_level_pick #(
            .NUM_SYM  (NUM_SYM),
            .SUM_W    (SUM_W),
            .IDX_W    (IDX_W),
            .LVL      (l),
            .HAS_FINE (l >= 1 && l >= FINE_LO && l <= FINE_HI)
        ) u_pick (
            .node_i  (sum_q.node[l]),
            .fine_i  (sum_q.fine[l]),
            .need_i  (overflow),
            .hit_o   (lvl_hit[l]),
            .start_o (lvl_start[l])
        );
    end

    // Stage 2: mode, burst count and trimmed span.
    always_comb begin
        sel_hit = 1'b0;
        sel_lvl = 0;
        for (int l = MAX_LVL; l >= 0; l--) begin
            if (lvl_hit[l]) begin
                sel_hit = 1'b1;
                sel_lvl = l;
            end
        end
        pick_d     = pick_q;
        pick_d.vld = sum_q.vld;
        if (sum_q.vld) begin
            pick_d.start = '0;
            pick_d.count = '0;
            if (is_raw) begin
                pick_d.mode   = MODE_RAW;
                pick_d.bursts = bcnt_safe;
            end else if (try_trim && sel_hit) begin
                pick_d.mode   = MODE_TRIMMED;
                pick_d.bursts = bcnt_tight;
                pick_d.start  = lvl_start[sel_lvl];
                pick_d.count  = CNT_W'(1 << sel_lvl);
            end else begin
                pick_d.mode   = MODE_EXACT;
                pick_d.bursts = bcnt_safe;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q  <= '0;
            pick_q <= '0;
        end else begin
            sum_q  <= sum_d;
            pick_q <= pick_d;
        end
    end

    assign out_valid  = pick_q.vld;
    assign out_mode   = pick_q.mode;
    assign out_bursts = pick_q.bursts;
    assign out_start  = pick_q.start;
    assign out_count  = pick_q.count;
endmodule

// File: rtl/aps_checker.sv
module aps_checker
    import aps_pkg::*;
#(
    parameter int NUM_SYM    = 64,
    parameter int MAX_APPROX = 16,
    parameter int IDX_W      = 6,
    parameter int CNT_W      = 5,
    parameter int BCNT_W     = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              out_valid,
    input logic [1:0]        out_mode,
    input logic [BCNT_W-1:0] out_bursts,
    input logic [IDX_W-1:0]  out_start,
    input logic [CNT_W-1:0]  out_count
);
    logic trimmed;
    assign trimmed = out_valid && (out_mode == MODE_TRIMMED);

    p_raw_fields_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mode == MODE_RAW) |-> (out_bursts == '1 && out_count == '0 && out_start == '0));

    p_exact_fields_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mode == MODE_EXACT) |-> (out_count == '0 && out_start == '0));

    p_mode_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_mode != 2'd3));

    p_span_fits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trimmed |-> (int'(out_start) + int'(out_count) <= NUM_SYM));

    p_span_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trimmed |-> ((out_count < 4) ? (int'(out_start) % int'(out_count) == 0)
                                     : (int'(out_start) % (int'(out_count) / 2) == 0)));

    p_count_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trimmed |-> ($countones(out_count) == 1 && int'(out_count) <= MAX_APPROX));

    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_mode) && $stable(out_bursts) && $stable(out_start) && $stable(out_count)));
endmodule

bind approx_span_selector aps_checker #(
    .NUM_SYM    (NUM_SYM),
    .MAX_APPROX (MAX_APPROX),
    .IDX_W      (IDX_W),
    .CNT_W      (CNT_W),
    .BCNT_W     (BCNT_W)
) u_aps_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .out_mode   (out_mode),
    .out_bursts (out_bursts),
    .out_start  (out_start),
    .out_count  (out_count)
);

// File: tb/approx_span_selector_bench.sv
`timescale 1ns/1ps
module approx_span_selector_bench;
    localparam int NS = 64;
    localparam int LW = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [NS*LW-1:0] in_lens = '0;
    logic [7:0]     in_thresh = '0;
    logic           out_valid;
    logic [1:0]     out_mode;
    logic [1:0]     out_bursts;
    logic [5:0]     out_start;
    logic [4:0]     out_count;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    int lens_a [NS];

    always #2.5 clk = ~clk;

    approx_span_selector u_approx_span_selector (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_lens    (in_lens),
        .in_thresh  (in_thresh),
        .out_valid  (out_valid),
        .out_mode   (out_mode),
        .out_bursts (out_bursts),
        .out_start  (out_start),
        .out_count  (out_count)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Reference: derived from the requirement list.
    task automatic model(input int thr, output int m, output int b, output int s,
                         output int c, output string tag);
        int size = 0;
        for (int i = 0; i < NS; i++) size += lens_a[i];
        m = 0; b = 0; s = 0; c = 0;
        if (size > 1024) begin
            m = 2; b = 3; tag = "R1";
        end else if (size < 256) begin
            tag = "R2";
        end else begin
            int nb = size / 256;
            int ex = size % 256;
            if (ex == 0) begin
                b = nb - 1; tag = "R3";
            end else if (ex > thr) begin
                b = nb; tag = "R5";
            end else begin
                bit found = 1'b0;
                for (int l = 0; l <= 4 && !found; l++) begin
                    int span = 1 << l;
                    int step = (l == 2 || l == 3) ? span / 2 : span;
                    for (int st = 0; st + span <= NS && !found; st += step) begin
                        if (st % span == 0 || st % (2 * span) == span / 2) begin
                            int acc = 0;
                            for (int j = st; j < st + span; j++) acc += lens_a[j];
                            if (acc >= ex) begin
                                found = 1'b1; s = st; c = span;
                            end
                        end
                    end
                end
                if (found) begin
                    m = 1; b = nb - 1; tag = "R4/R6";
                end else begin
                    b = nb; tag = "R9";
                end
            end
        end
    endtask

    task automatic run_case(input int thr, input string force_tag);
        int m, b, s, c;
        string tag;
        int pm, pb, ps, pc;
        model(thr, m, b, s, c, tag);
        if (force_tag != "") tag = force_tag;
        for (int i = 0; i < NS; i++) in_lens[i*LW +: LW] = LW'(lens_a[i]);
        @(negedge clk);
        pm = out_mode; pb = out_bursts; ps = out_start; pc = out_count;
        in_thresh = 8'(thr);
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R10", "out_valid after 1 cycle", int'(out_valid), 0);
        check("R10", "held mode", int'(out_mode), pm);
        check("R10", "held fields", int'(out_bursts) + 4 * int'(out_start) + 256 * int'(out_count),
              pb + 4 * ps + 256 * pc);
        @(negedge clk);
        check("R10", "out_valid after 2 cycles", int'(out_valid), 1);
        check(tag, "mode", int'(out_mode), m);
        check(tag, "bursts", int'(out_bursts), b);
        check(tag, "start", int'(out_start), s);
        check(tag, "count", int'(out_count), c);
    endtask

    task automatic fill(input int v);
        for (int i = 0; i < NS; i++) lens_a[i] = v;
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R11", "reset valid", int'(out_valid), 0);
        check("R11", "reset fields", int'(out_mode) + int'(out_bursts) + int'(out_start) + int'(out_count), 0);
        rst_n = 1'b1;

        fill(31); run_case(255, "R1");
        fill(0);  run_case(0, "R2");
        fill(16); run_case(0, "R3");
        fill(4);  run_case(0, "R3");
        fill(4); lens_a[10] = 5; run_case(8, "R4");
        fill(7); run_case(100, "R5");
        fill(7); run_case(255, "R9");
        fill(5); run_case(255, "R6");
        // R8: only the offset span 2..5 covers 50 bits
        fill(0); lens_a[3] = 31; lens_a[4] = 31;
        for (int i = 16; i < 36; i++) lens_a[i] = 12;
        lens_a[36] = 4;
        run_case(60, "R8");
        // R7: symbols 5 and 9 both cover 20 bits; the lower start wins
        fill(0); lens_a[5] = 20; lens_a[9] = 20; lens_a[31] = 12;
        for (int i = 32; i < 64; i++) lens_a[i] = 7;
        run_case(20, "R7");

        for (int n = 0; n < 400; n++) begin
            int mx = $urandom % 32;
            for (int i = 0; i < NS; i++) lens_a[i] = $urandom % (mx + 1);
            run_case($urandom % 256, "");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule